// File: doc/BRIEF.md
# Multiplexed-Bus Register Interface Unit

This block is the processor-facing front end of a combined memory, I/O and timer peripheral. The peripheral sits on an 8-bit bus where the address and the data share the same wires. A falling address strobe captures the address byte, the chip-enable level and the memory/IO select. The read and write strobes that follow are steered either to an internal byte-wide memory or to a small file of I/O registers.

The unit holds the command register and builds the status word. It controls the drive-enable of the shared bus. Port pin logic and timer counting logic sit outside. They receive direction and mode outputs, a forwarded register-write pulse and a timer command pulse. They return their read values and status flags through plain inputs.

A build-time parameter selects whether the chip enable is active high or active low. Every strobe is sampled on the system clock.

Top module: `mbus_regif`

## Requirements
- R1: On the clock where `ale` is seen falling (high on the previous clock, low now), the unit captures `ad_in`, `io_sel` and `ce`. Later read and write strobes use only these captured values, whatever those inputs do afterwards.
- R2: With the captured `io_sel` low, a write stores `ad_in` into a 256-entry byte memory at the captured address, and a read returns that byte.
- R3: With the captured `io_sel` high, only the low three captured address bits select the target: 0 command/status, 1 port A, 2 port B, 3 port C (6 bits, zero-extended), 4 timer low byte, 5 timer high byte. Upper address bits have no effect.
- R4: With `CE_ACT_HIGH`=0 the chip enable is active when `ce` is low; with 1 it is active when `ce` is high. If the enable was inactive when the address was captured, writes change nothing and reads leave the bus undriven.
- R5: A write to I/O address 0 loads the command register. Bit 0 goes to `pa_out`, bit 1 to `pb_out`, bits 3:2 to `pc_mode`, bit 4 to `ie_a`, bit 5 to `ie_b` and bits 7:6 to `tmr_cmd`. A read of address 0 never returns the command register.
- R6: A read of I/O address 0 returns the status word: bit0 `a_intr`, bit1 `a_bf`, bit2 port A interrupt enable, bit3 `b_intr`, bit4 `b_bf`, bit5 port B interrupt enable, bit6 timer flag, bit7 zero.
- R7: A `tmr_tc` pulse sets the timer flag on the next clock. The clock on which the read strobe rises at the end of a status read clears the flag. If a set and a clear fall on the same clock, the set wins. Reset clears the flag.
- R8: While `rst` is high, every command field is zero: all ports are inputs, port C is in plain input mode, interrupts are disabled and the timer command is 0.
- R9: `ad_oe` is high only while `rd_n` is low, the captured enable is active, and the target is memory or I/O address 0 to 5. I/O addresses 6 and 7 are never driven. `ad_out` is zero whenever `ad_oe` is low.
- R10: `tmr_cmd_pulse` is high for exactly one clock, on the clock after a write to I/O address 0 whose bits 7:6 are non-zero. A write with bits 7:6 equal to zero gives no pulse.
- R11: A write to I/O addresses 1 to 5 raises `reg_wr_en` for one clock, on the clock after the strobe. `reg_wr_addr` carries the 3-bit address and `reg_wr_data` the written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous reset, active high |
| ale | input | 1 | Address strobe; capture on its falling edge |
| ad_in | input | 8 | Shared address/data bus, incoming |
| ce | input | 1 | Chip enable, polarity set by CE_ACT_HIGH |
| io_sel | input | 1 | 0 = memory, 1 = I/O registers |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| ad_out | output | 8 | Shared bus, outgoing data |
| ad_oe | output | 1 | Drive enable for ad_out |
| pa_out | output | 1 | Port A direction, 1 = output |
| pb_out | output | 1 | Port B direction, 1 = output |
| pc_mode | output | 2 | Port C mode field |
| ie_a | output | 1 | Port A interrupt enable |
| ie_b | output | 1 | Port B interrupt enable |
| tmr_cmd | output | 2 | Timer command field |
| tmr_cmd_pulse | output | 1 | One-clock timer command strobe |
| reg_wr_en | output | 1 | Forwarded I/O register write |
| reg_wr_addr | output | 3 | Forwarded write address |
| reg_wr_data | output | 8 | Forwarded write data |
| pa_rd | input | 8 | Port A read value |
| pb_rd | input | 8 | Port B read value |
| pc_rd | input | 6 | Port C read value |
| tlo_rd | input | 8 | Timer low byte read value |
| thi_rd | input | 8 | Timer high byte read value |
| a_intr | input | 1 | Port A interrupt request |
| a_bf | input | 1 | Port A buffer full |
| b_intr | input | 1 | Port B interrupt request |
| b_bf | input | 1 | Port B buffer full |
| tmr_tc | input | 1 | Timer terminal-count pulse |

## Verification
The bench changes `ce` and `io_sel` after the address strobe and checks that the access still goes where it was captured. A design that decodes live pins would send such a read to the wrong target or fail to drive the bus. It reads I/O address 0 after a command write. Returning the command byte there would show the two registers sharing one storage. It reads the status word twice after a terminal count: the first read must show the flag and the second must not. Clearing at the start of the read would lose the flag, and never clearing would leave it stuck. It also checks addresses with set upper bits and the unused codes 6 and 7, and a command write with an idle timer field, where a loosely decoded pulse would fire anyway.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
   localparam logic [2:0] IO_CS  = 3'd0;
   localparam logic [2:0] IO_PA  = 3'd1;
   localparam logic [2:0] IO_PB  = 3'd2;
   localparam logic [2:0] IO_PC  = 3'd3;
   localparam logic [2:0] IO_TLO = 3'd4;
   localparam logic [2:0] IO_THI = 3'd5;

   typedef struct packed {
      logic [1:0] tcmd;
      logic       ie_b;
      logic       ie_a;
      logic [1:0] pc_mode;
      logic       pb_out;
      logic       pa_out;
   } cmd_t;

   typedef struct packed {
      logic rsvd;
      logic tflag;
      logic ie_b;
      logic bf_b;
      logic intr_b;
      logic ie_a;
      logic bf_a;
      logic intr_a;
   } stat_t;
endpackage

// File: rtl/mbus_latch.sv
module mbus_latch #(
   parameter bit CE_ACT_HIGH = 1'b0,
   parameter int BW          = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          ale,
   input  logic [BW-1:0] ad_in,
   input  logic          ce,
   input  logic          io_sel,
   input  logic          rd_n,
   input  logic          wr_n,
   output logic [BW-1:0] lat_addr,
   output logic          lat_io,
   output logic          lat_sel,
   output logic          wr_stb,
   output logic          rd_end,
   output logic          rd_act
);
   logic ce_act, ale_q, rd_q, wr_q, ale_fall;

   generate
      if (CE_ACT_HIGH) begin : g_ce_hi
         assign ce_act = ce;
      end else begin : g_ce_lo
         assign ce_act = ~ce;
      end
   endgenerate

   assign ale_fall = ale_q & ~ale;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         ale_q    <= 1'b0;
         rd_q     <= 1'b1;
         wr_q     <= 1'b1;
         lat_addr <= '0;
         lat_io   <= 1'b0;
         lat_sel  <= 1'b0;
      end else begin
         ale_q <= ale;
         rd_q  <= rd_n;
         wr_q  <= wr_n;
         if (ale_fall) begin
            lat_addr <= ad_in;
            lat_io   <= io_sel;
            lat_sel  <= ce_act;
         end
      end
   end

   assign wr_stb = wr_q & ~wr_n & lat_sel;
   assign rd_end = ~rd_q & rd_n & lat_sel;
   assign rd_act = ~rd_n & lat_sel;

   p_addr_capture_r1: assert property (@(posedge clk) disable iff (rst)
      ale_fall |=> (lat_addr == $past(ad_in)) && (lat_io == $past(io_sel)));
   p_addr_hold_r1: assert property (@(posedge clk) disable iff (rst)
      !ale_fall |=> $stable(lat_addr) && $stable(lat_sel));
endmodule

// File: rtl/mbus_ram.sv
module mbus_ram #(
   parameter int AW = 8,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wdata;
   end

   assign rdata = mem[addr];
endmodule

// File: rtl/mbus_ctl.sv
module mbus_ctl
   import mbus_pkg::*;
#(
   parameter int BW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          io_wr,
   input  logic [2:0]    sel,
   input  logic [BW-1:0] wdata,
   input  logic          stat_rd_end,
   input  logic          tmr_tc,
   output cmd_t          cmd,
   output logic          tflag,
   output logic          tmr_cmd_pulse,
   output logic          reg_wr_en,
   output logic [2:0]    reg_wr_addr,
   output logic [BW-1:0] reg_wr_data
);
   logic cmd_wr, fwd_wr;

   assign cmd_wr = io_wr & (sel == IO_CS);
   assign fwd_wr = io_wr & (sel >= IO_PA) & (sel <= IO_THI);

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         cmd           <= '0;
         tflag         <= 1'b0;
         tmr_cmd_pulse <= 1'b0;
         reg_wr_en     <= 1'b0;
         reg_wr_addr   <= '0;
         reg_wr_data   <= '0;
      end else begin
         tmr_cmd_pulse <= cmd_wr & (wdata[7:6] != 2'b00);
         if (cmd_wr) cmd <= cmd_t'(wdata[7:0]);
         reg_wr_en <= fwd_wr;
         if (fwd_wr) begin
            reg_wr_addr <= sel;
            reg_wr_data <= wdata;
         end
         if (tmr_tc)           tflag <= 1'b1;
         else if (stat_rd_end) tflag <= 1'b0;
      end
   end

   p_flag_set_r7: assert property (@(posedge clk) disable iff (rst)
      tmr_tc |=> tflag);
   p_pulse_single_r10: assert property (@(posedge clk) disable iff (rst)
      tmr_cmd_pulse |=> !tmr_cmd_pulse);
   p_pulse_cmd_r10: assert property (@(posedge clk) disable iff (rst)
      tmr_cmd_pulse |-> (cmd.tcmd != 2'b00));
   p_fwd_range_r11: assert property (@(posedge clk) disable iff (rst)
      reg_wr_en |-> (reg_wr_addr != IO_CS) && (reg_wr_addr <= IO_THI));
endmodule

// File: rtl/mbus_rdmux.sv
module mbus_rdmux
   import mbus_pkg::*;
#(
   parameter int BW  = 8,
   parameter int PCW = 6
) (
   input  logic           lat_io,
   input  logic [2:0]     sel,
   input  logic           rd_act,
   input  logic [BW-1:0]  ram_rdata,
   input  stat_t          status,
   input  logic [BW-1:0]  pa_rd,
   input  logic [BW-1:0]  pb_rd,
   input  logic [PCW-1:0] pc_rd,
   input  logic [BW-1:0]  tlo_rd,
   input  logic [BW-1:0]  thi_rd,
   output logic [BW-1:0]  ad_out,
   output logic           ad_oe
);
   logic          tgt_ok;
   logic [BW-1:0] io_val;

   assign tgt_ok = ~lat_io | (sel <= IO_THI);
   assign ad_oe  = rd_act & tgt_ok;

   always_comb begin
      io_val = '0;
      case (sel)
         IO_CS:   io_val[7:0] = status;
         IO_PA:   io_val = pa_rd;
         IO_PB:   io_val = pb_rd;
         IO_PC:   io_val[PCW-1:0] = pc_rd;
         IO_TLO:  io_val = tlo_rd;
         IO_THI:  io_val = thi_rd;
         default: io_val = '0;
      endcase
   end

   assign ad_out = !ad_oe ? '0 : (lat_io ? io_val : ram_rdata);
endmodule

// File: rtl/mbus_regif.sv
module mbus_regif
   import mbus_pkg::*;
#(
   parameter bit CE_ACT_HIGH = 1'b0,
   parameter int BW          = 8,
   parameter int MAW         = 8,
   parameter int PCW         = 6
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           ale,
   input  logic [BW-1:0]  ad_in,
   input  logic           ce,
   input  logic           io_sel,
   input  logic           rd_n,
   input  logic           wr_n,
   output logic [BW-1:0]  ad_out,
   output logic           ad_oe,
   output logic           pa_out,
   output logic           pb_out,
   output logic [1:0]     pc_mode,
   output logic           ie_a,
   output logic           ie_b,
   output logic [1:0]     tmr_cmd,
   output logic           tmr_cmd_pulse,
   output logic           reg_wr_en,
   output logic [2:0]     reg_wr_addr,
   output logic [BW-1:0]  reg_wr_data,
   input  logic [BW-1:0]  pa_rd,
   input  logic [BW-1:0]  pb_rd,
   input  logic [PCW-1:0] pc_rd,
   input  logic [BW-1:0]  tlo_rd,
   input  logic [BW-1:0]  thi_rd,
   input  logic           a_intr,
   input  logic           a_bf,
   input  logic           b_intr,
   input  logic           b_bf,
   input  logic           tmr_tc
);
   generate
      if (BW != 8) begin : g_bad_bw
         $error("mbus_regif: BW must be 8");
      end
      if (MAW > BW || MAW < 1) begin : g_bad_maw
         $error("mbus_regif: MAW must be 1..BW");
      end
      if (PCW > BW || PCW < 1) begin : g_bad_pcw
         $error("mbus_regif: PCW must be 1..BW");
      end
   endgenerate

   logic [BW-1:0] lat_addr, ram_rdata;
   logic          lat_io, lat_sel, wr_stb, rd_end, rd_act, tflag;
   cmd_t          cmd;
   stat_t         status;

   mbus_latch #(.CE_ACT_HIGH(CE_ACT_HIGH), .BW(BW)) u_latch (
      .clk(clk), .rst(rst), .ale(ale), .ad_in(ad_in), .ce(ce),
      .io_sel(io_sel), .rd_n(rd_n), .wr_n(wr_n), .lat_addr(lat_addr),
      .lat_io(lat_io), .lat_sel(lat_sel), .wr_stb(wr_stb),
      .rd_end(rd_end), .rd_act(rd_act));

   mbus_ram #(.AW(MAW), .DW(BW)) u_ram (
      .clk(clk), .we(wr_stb & ~lat_io), .addr(lat_addr[MAW-1:0]),
      .wdata(ad_in), .rdata(ram_rdata));

   mbus_ctl #(.BW(BW)) u_ctl (
      .clk(clk), .rst(rst), .io_wr(wr_stb & lat_io), .sel(lat_addr[2:0]),
      .wdata(ad_in), .stat_rd_end(rd_end & lat_io & (lat_addr[2:0] == IO_CS)),
      .tmr_tc(tmr_tc), .cmd(cmd), .tflag(tflag),
      .tmr_cmd_pulse(tmr_cmd_pulse), .reg_wr_en(reg_wr_en),
      .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data));

   always_comb begin
      status        = '0;
      status.intr_a = a_intr;
      status.bf_a   = a_bf;
      status.ie_a   = cmd.ie_a;
      status.intr_b = b_intr;
      status.bf_b   = b_bf;
      status.ie_b   = cmd.ie_b;
      status.tflag  = tflag;
   end

   mbus_rdmux #(.BW(BW), .PCW(PCW)) u_rdmux (
      .lat_io(lat_io), .sel(lat_addr[2:0]), .rd_act(rd_act),
      .ram_rdata(ram_rdata), .status(status), .pa_rd(pa_rd), .pb_rd(pb_rd),
      .pc_rd(pc_rd), .tlo_rd(tlo_rd), .thi_rd(thi_rd),
      .ad_out(ad_out), .ad_oe(ad_oe));

   assign pa_out  = cmd.pa_out;
   assign pb_out  = cmd.pb_out;
   assign pc_mode = cmd.pc_mode;
   assign ie_a    = cmd.ie_a;
   assign ie_b    = cmd.ie_b;
   assign tmr_cmd = cmd.tcmd;

   p_oe_needs_rd_r9: assert property (@(posedge clk) disable iff (rst)
      ad_oe |-> !rd_n);
   p_quiet_bus_r9: assert property (@(posedge clk) disable iff (rst)
      !ad_oe |-> (ad_out == '0));
   p_cmd_from_write_r5: assert property (@(posedge clk) disable iff (rst)
      (tmr_cmd != $past(tmr_cmd)) |-> $past(wr_stb & lat_io));
endmodule

// File: tb/tb_mbus_regif.sv
`timescale 1ns/1ps
module tb_mbus_regif;
   localparam bit CEH = 1'b0;
   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic       rst, ale, ce, io_sel, rd_n, wr_n;
   logic [7:0] ad_in, pa_rd, pb_rd, tlo_rd, thi_rd;
   logic [5:0] pc_rd;
   logic       a_intr, a_bf, b_intr, b_bf, tmr_tc;
   logic [7:0] ad_out, reg_wr_data;
   logic       ad_oe, pa_out, pb_out, ie_a, ie_b, tmr_cmd_pulse, reg_wr_en;
   logic [1:0] pc_mode, tmr_cmd;
   logic [2:0] reg_wr_addr;

   mbus_regif #(.CE_ACT_HIGH(CEH)) dut (
      .clk(clk), .rst(rst), .ale(ale), .ad_in(ad_in), .ce(ce), .io_sel(io_sel),
      .rd_n(rd_n), .wr_n(wr_n), .ad_out(ad_out), .ad_oe(ad_oe),
      .pa_out(pa_out), .pb_out(pb_out), .pc_mode(pc_mode), .ie_a(ie_a),
      .ie_b(ie_b), .tmr_cmd(tmr_cmd), .tmr_cmd_pulse(tmr_cmd_pulse),
      .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
      .reg_wr_data(reg_wr_data), .pa_rd(pa_rd), .pb_rd(pb_rd), .pc_rd(pc_rd),
      .tlo_rd(tlo_rd), .thi_rd(thi_rd), .a_intr(a_intr), .a_bf(a_bf),
      .b_intr(b_intr), .b_bf(b_bf), .tmr_tc(tmr_tc));

   int checks = 0, failures = 0;
   bit done = 0;

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // reference model state
   logic [7:0] m_mem [256];
   bit         m_mv  [256];
   logic [7:0] m_addr, m_cmd, m_wdata;
   bit         m_io, m_ce, m_flag, m_pulse, m_wen, m_pale, m_prd, m_pwr;
   int         m_waddr;

   function automatic bit m_act();
      return m_ce == CEH;
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         m_addr = 0; m_io = 0; m_ce = !CEH; m_cmd = 0; m_flag = 0;
         m_pulse = 0; m_wen = 0; m_waddr = 0; m_wdata = 0;
         m_pale = 0; m_prd = 1; m_pwr = 1;
      end else begin
         m_pulse = 0; m_wen = 0;
         if (m_pwr && !wr_n && m_act()) begin
            if (!m_io) begin
               m_mem[m_addr] = ad_in; m_mv[m_addr] = 1;
            end else if (m_addr % 8 == 0) begin
               m_cmd = ad_in; m_pulse = (ad_in / 64) != 0;
            end else if (m_addr % 8 <= 5) begin
               m_wen = 1; m_waddr = m_addr % 8; m_wdata = ad_in;
            end
         end
         if (!m_prd && rd_n && m_act() && m_io && m_addr % 8 == 0) m_flag = 0;
         if (tmr_tc) m_flag = 1;
         if (m_pale && !ale) begin
            m_addr = ad_in; m_io = io_sel; m_ce = ce;
         end
         m_pale = ale; m_prd = rd_n; m_pwr = wr_n;
      end
      #2;
      if (!rst && !done) begin : cmp
         bit eoe;
         int ev;
         eoe = !rd_n && m_act() && (!m_io || (m_addr % 8) <= 5);
         ev = 0;
         if (eoe) begin
            if (!m_io) ev = m_mv[m_addr] ? int'(m_mem[m_addr]) : int'(ad_out);
            else case (m_addr % 8)
               0: ev = {1'b0, m_flag, m_cmd[5], b_bf, b_intr, m_cmd[4], a_bf, a_intr};
               1: ev = pa_rd;
               2: ev = pb_rd;
               3: ev = {2'b00, pc_rd};
               4: ev = tlo_rd;
               default: ev = thi_rd;
            endcase
         end
         check("R9 bus", {ad_oe, ad_out}, {eoe, ev[7:0]});
         check("R5 cmd outputs", {tmr_cmd, ie_b, ie_a, pc_mode, pb_out, pa_out}, m_cmd);
         check("R10 pulse", tmr_cmd_pulse, m_pulse);
         check("R11 fwd en", reg_wr_en, m_wen);
         if (m_wen) check("R11 fwd addr/data", {reg_wr_addr, reg_wr_data}, {m_waddr[2:0], m_wdata});
      end
   end

   // bus tasks
   task automatic bus_addr(input bit io, input bit cel, input logic [7:0] a);
      @(negedge clk); ale = 1; ad_in = a; io_sel = io; ce = cel;
      @(negedge clk); ale = 0;
      @(negedge clk);
   endtask

   logic p_seen, w_seen;
   task automatic bus_write(input logic [7:0] d);
      @(negedge clk); ad_in = d; wr_n = 0;
      @(posedge clk); #2; p_seen = tmr_cmd_pulse; w_seen = reg_wr_en;
      @(negedge clk); wr_n = 1;
      @(negedge clk);
   endtask

   task automatic bus_read(output logic [7:0] d, output logic oe);
      @(negedge clk); rd_n = 0; ad_in = 8'h00;
      @(posedge clk); #2; d = ad_out; oe = ad_oe;
      @(negedge clk); rd_n = 1;
      @(negedge clk);
   endtask

   localparam bit ON = CEH, OFF = !CEH;

   initial begin : wdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog expired");
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : stim
      logic [7:0] d;
      logic oe;
      rst = 1; ale = 0; ce = OFF; io_sel = 0; rd_n = 1; wr_n = 1; ad_in = 0;
      pa_rd = 8'h11; pb_rd = 8'h22; pc_rd = 6'h2B; tlo_rd = 8'h44; thi_rd = 8'hC5;
      a_intr = 0; a_bf = 0; b_intr = 0; b_bf = 0; tmr_tc = 0;
      repeat (3) @(negedge clk);
      check("R8 reset fields", {tmr_cmd, ie_b, ie_a, pc_mode, pb_out, pa_out}, 0);
      check("R8 reset bus", {ad_oe, ad_out}, 0);
      rst = 0;
      @(negedge clk);

      // R2 memory
      bus_addr(0, ON, 8'h3C); bus_write(8'hA5);
      bus_addr(0, ON, 8'h3D); bus_write(8'h5A);
      bus_addr(0, ON, 8'hFF); bus_write(8'h81);
      bus_addr(0, ON, 8'h3C); bus_read(d, oe);
      check("R2 mem 3C", {oe, d}, {1'b1, 8'hA5});
      bus_addr(0, ON, 8'hFF); bus_read(d, oe);
      check("R2 mem FF", {oe, d}, {1'b1, 8'h81});

      // R1 captured values survive pin changes
      bus_addr(0, ON, 8'h3D);
      io_sel = 1; ce = OFF;
      bus_read(d, oe);
      check("R1 latched target", {oe, d}, {1'b1, 8'h5A});

      // R3 decode ignores upper bits
      bus_addr(1, ON, 8'hF9); bus_read(d, oe);
      check("R3 port A", d, 8'h11);
      bus_addr(1, ON, 8'h2B); bus_read(d, oe);
      check("R3 port C", d, 8'h2B);
      bus_addr(1, ON, 8'h0D); bus_read(d, oe);
      check("R3 timer high", d, 8'hC5);

      // R4 inactive enable
      bus_addr(0, OFF, 8'h3C); bus_write(8'h00); bus_read(d, oe);
      check("R4 no drive", {oe, d}, 0);
      bus_addr(0, ON, 8'h3C); bus_read(d, oe);
      check("R4 mem unchanged", d, 8'hA5);

      // R5 command register, R10 idle timer field
      bus_addr(1, ON, 8'h00); bus_write(8'h3D);
      check("R10 no pulse for 00", p_seen, 0);
      check("R5 fields", {tmr_cmd, ie_b, ie_a, pc_mode, pb_out, pa_out}, 8'h3D);
      // R6 status word
      a_intr = 1; b_bf = 1;
      bus_read(d, oe);
      check("R5 R6 status not command", {oe, d}, {1'b1, 8'h35});

      // R7 timer flag
      @(negedge clk); tmr_tc = 1; @(negedge clk); tmr_tc = 0;
      bus_read(d, oe);
      check("R7 flag set", d, 8'h75);
      bus_read(d, oe);
      check("R7 flag cleared", d, 8'h35);

      // R9 unused addresses
      bus_addr(1, ON, 8'hFE); bus_read(d, oe);
      check("R9 addr 6", {oe, d}, 0);
      bus_addr(1, ON, 8'h07); bus_read(d, oe);
      check("R9 addr 7", {oe, d}, 0);

      // R10 pulse
      bus_addr(1, ON, 8'h08); bus_write(8'hC2);
      check("R10 pulse", p_seen, 1);
      check("R10 cmd", tmr_cmd, 3);

      // R11 forwarded write
      bus_addr(1, ON, 8'h05); bus_write(8'h9C);
      check("R11 fwd", w_seen, 1);
      bus_addr(1, ON, 8'h06); bus_write(8'h77);
      check("R11 no fwd for 6", w_seen, 0);

      // R8 reset mid-run
      @(negedge clk); rst = 1;
      @(negedge clk);
      check("R8 reset again", {tmr_cmd, ie_b, ie_a, pc_mode, pb_out, pa_out}, 0);
      rst = 0;
      repeat (3) @(negedge clk);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule